// File: doc/BRIEF.md
# Rotating and Zooming Tilemap Address Generator

This block produces one graphics address per displayed pixel for a single tilemap that can be rotated, zoomed and sheared. The map is 32 by 32 tiles of 16 by 16 pixels each, so the playfield is 512 by 512 pixels. Two signed 24-bit fixed-point accumulators track the X and Y position in the map. Each one has 11 fractional bits. The accumulators move by one pair of step values for every pixel and by a second pair for every new line. Because of this, any affine mapping from the screen to the map costs only two adders per axis.

For every pixel strobe the block looks up the 16-bit entry of the tile under the current position in an internal tile RAM, which a CPU fills through a write port. It then registers a 24-bit address made of that entry, the row within the tile and the column within the tile. It also registers a flag that says whether the position lay inside the 512 by 512 map. Out-of-range positions still give a wrapped address. Turning the address into a colour is left to external graphics memory and palette logic.

A small sequencer has three states. S_IDLE is the state after reset. S_TOP means a frame has started but its first line has not. S_SCAN means lines are being drawn. The sequencer turns the frame, line and pixel strobes into one command per cycle: LOAD, LINE0, LINEN, PIX or NONE. The transitions are:
- S_IDLE goes to S_TOP on frame_start.
- S_TOP goes to S_SCAN on line_start.
- S_SCAN stays in S_SCAN on line_start.
- Every state goes to S_TOP on frame_start.
- line_start in S_IDLE issues LINE0 and stays in S_IDLE.

If several strobes arrive in the same cycle, frame_start wins over line_start, and line_start wins over pix_en.

Top module: `rot_zoom_addr_gen`

## Requirements
- R1: After reset, gfx_valid, gfx_visible and gfx_addr are all zero.
- R2: frame_start loads start_x/start_y into both the line-start and the pixel accumulators of the matching axis.
- R3: The first line_start after frame_start (or any line_start before the first frame) copies the line-start values into the pixel accumulators without stepping them.
- R4: Every later line_start within a frame adds dxdy to the X line-start value and dydy to the Y line-start value, then reloads the pixel accumulators with the new sums.
- R5: Each pix_en produces the address for the current accumulator values, then adds dxdx to X and dydx to Y, modulo 2^24.
- R6: The map coordinate of an axis is accumulator bits [23:11], read as a signed 13-bit number. Its lower 9 bits, bits [19:11], are the truncated pixel coordinate.
- R7: gfx_addr = {entry, y[3:0], x[3:0]}. Here x and y are the truncated coordinates, and entry is the tile RAM word at index {y[8:4], x[8:4]}, that is Y tile row in bits [9:5] and X tile column in bits [4:0].
- R8: gfx_visible is 1 exactly when both coordinates lie in 0..511 (accumulator bits [23:20] all zero on both axes). The wrapped address is produced either way.
- R9: gfx_valid is 1 in the cycle after each pix_en, and only then. gfx_addr and gfx_visible change only in that cycle and hold their values otherwise.
- R10: cpu_we writes cpu_wdata into the tile RAM word at cpu_addr. Pixels fetched later use the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe at the top of a frame |
| line_start | input | 1 | One-cycle strobe at the start of a line |
| pix_en | input | 1 | One-cycle strobe per displayed pixel |
| start_x | input | 24 | X start value, 11 fractional bits |
| start_y | input | 24 | Y start value, 11 fractional bits |
| dxdx | input | 24 | X step per pixel |
| dydx | input | 24 | Y step per pixel |
| dxdy | input | 24 | X step per line |
| dydy | input | 24 | Y step per line |
| cpu_we | input | 1 | Tile RAM write enable |
| cpu_addr | input | 10 | Tile RAM word index |
| cpu_wdata | input | 16 | Tile RAM write data |
| gfx_addr | output | 24 | Graphics address for the last strobed pixel |
| gfx_visible | output | 1 | Last strobed pixel lay inside the map |
| gfx_valid | output | 1 | gfx_addr and gfx_visible were updated this cycle |

## Verification
The assertions assume that the three strobes are mutually exclusive. They also assume that the step and start inputs are held constant around each strobe. The stimulus keeps to both: every strobe comes from its own task, and the configuration changes only between frames. Tile RAM writes never share a cycle with a pixel strobe, so the checks never depend on read-during-write ordering. The patterns cover:
- identity mapping;
- half-scale zoom;
- a sheared and rotated step set that crosses tile boundaries;
- negative start values that leave the map and wrap.

// File: rtl/rzt_pkg.sv
package rzt_pkg;
    localparam int ACC_W  = 24;
    localparam int FRAC_W = 11;
    localparam int MAP_W  = 9;
    localparam int TILE_W = 4;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        S_IDLE,
        S_TOP,
        S_SCAN
    } seq_state_t;

    typedef enum logic [2:0] {
        C_NONE,
        C_LOAD,
        C_LINE0,
        C_LINEN,
        C_PIX
    } axis_cmd_t;
endpackage

// File: rtl/rzt_seq.sv
module rzt_seq
    import rzt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_start,
    input  logic      line_start,
    input  logic      pix_en,
    output axis_cmd_t cmd
);
    seq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        cmd      = C_NONE;
        if (frame_start) begin
            state_nx = S_TOP;
            cmd      = C_LOAD;
        end else if (line_start) begin
            unique case (state)
                S_IDLE: cmd = C_LINE0;
                S_TOP: begin
                    cmd      = C_LINE0;
                    state_nx = S_SCAN;
                end
                S_SCAN: cmd = C_LINEN;
                default: cmd = C_NONE;
            endcase
        end else if (pix_en) begin
            cmd = C_PIX;
        end
    end

    AST_FRAME_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> state == S_TOP); // R2
    AST_LINE_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start && state != S_IDLE) |=> state == S_SCAN); // R3
endmodule

// File: rtl/rzt_axis.sv
module rzt_axis
    import rzt_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int FW = FRAC_W,
    parameter int MW = MAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  axis_cmd_t     cmd,
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] d_pix,
    input  logic [AW-1:0] d_line,
    output logic [MW-1:0] coord,
    output logic          in_range
);
    localparam int HI_W = AW - FW - MW;

    logic [AW-1:0] line_acc, pix_acc;
    logic [AW-1:0] line_next;

    assign line_next = line_acc + d_line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_acc <= '0;
            pix_acc  <= '0;
        end else begin
            unique case (cmd)
                C_LOAD: begin
                    line_acc <= start;
                    pix_acc  <= start;
                end
                C_LINE0: pix_acc <= line_acc;
                C_LINEN: begin
                    line_acc <= line_next;
                    pix_acc  <= line_next;
                end
                C_PIX:   pix_acc <= pix_acc + d_pix;
                default: ;
            endcase
        end
    end

    assign coord    = pix_acc[FW+MW-1:FW];
    assign in_range = (pix_acc[AW-1:AW-HI_W] == '0);

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_LOAD |=> line_acc == $past(start)); // R2
    AST_LINE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_LINE0 || cmd == C_LINEN) |=> pix_acc == line_acc); // R4
    AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_PIX |=> pix_acc == $past(pix_acc) + $past(d_pix)); // R5
endmodule

// File: rtl/rzt_tile_ram.sv
module rzt_tile_ram #(
    parameter int IW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rot_zoom_addr_gen.sv
module rot_zoom_addr_gen
    import rzt_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int FW = FRAC_W,
    parameter int MW = MAP_W,
    parameter int TW = TILE_W,
    parameter int DW = DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      line_start,
    input  logic                      pix_en,
    input  logic [AW-1:0]             start_x,
    input  logic [AW-1:0]             start_y,
    input  logic [AW-1:0]             dxdx,
    input  logic [AW-1:0]             dydx,
    input  logic [AW-1:0]             dxdy,
    input  logic [AW-1:0]             dydy,
    input  logic                      cpu_we,
    input  logic [2*(MW-TW)-1:0]      cpu_addr,
    input  logic [DW-1:0]             cpu_wdata,
    output logic [DW+2*TW-1:0]        gfx_addr,
    output logic                      gfx_visible,
    output logic                      gfx_valid
);
    localparam int IW = 2 * (MW - TW);
    localparam int OW = DW + 2 * TW;

    axis_cmd_t     cmd;
    logic [AW-1:0] st   [2];
    logic [AW-1:0] dpx  [2];
    logic [AW-1:0] dln  [2];
    logic [MW-1:0] crd  [2];
    logic [1:0]    inr;
    logic [IW-1:0] ridx;
    logic [DW-1:0] entry;

    assign st[0]  = start_x;
    assign st[1]  = start_y;
    assign dpx[0] = dxdx;
    assign dpx[1] = dydx;
    assign dln[0] = dxdy;
    assign dln[1] = dydy;

    rzt_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_start  (line_start),
        .pix_en      (pix_en),
        .cmd         (cmd)
    );

    for (genvar g = 0; g < 2; g++) begin : g_axis
        rzt_axis #(.AW(AW), .FW(FW), .MW(MW)) u_axis (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd),
            .start    (st[g]),
            .d_pix    (dpx[g]),
            .d_line   (dln[g]),
            .coord    (crd[g]),
            .in_range (inr[g])
        );
    end

    assign ridx = {crd[1][MW-1:TW], crd[0][MW-1:TW]};

    rzt_tile_ram #(.IW(IW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (cpu_we),
        .waddr (cpu_addr),
        .wdata (cpu_wdata),
        .raddr (ridx),
        .rdata (entry)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gfx_addr    <= '0;
            gfx_visible <= 1'b0;
            gfx_valid   <= 1'b0;
        end else begin
            gfx_valid <= (cmd == C_PIX);
            if (cmd == C_PIX) begin
                gfx_addr    <= OW'({entry, crd[1][TW-1:0], crd[0][TW-1:0]});
                gfx_visible <= &inr;
            end
        end
    end

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !frame_start && !line_start) |=> gfx_valid); // R9
    AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> !gfx_valid); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable(gfx_addr) && $stable(gfx_visible))); // R9
endmodule

// File: tb/tb_rot_zoom_addr_gen.sv
module tb_rot_zoom_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, line_start = 1'b0, pix_en = 1'b0;
    logic [23:0] start_x = '0, start_y = '0, dxdx = '0, dydx = '0, dxdy = '0, dydy = '0;
    logic        cpu_we = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [23:0] gfx_addr;
    logic        gfx_visible, gfx_valid;

    int total = 0;
    int bad = 0;

    logic [15:0] ram_m [1024];
    logic [23:0] lx, ly, px, py;
    bit          first_line = 1'b1;
    logic [24:0] expq [$];

    always #5 clk = ~clk;

    rot_zoom_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .pix_en(pix_en), .start_x(start_x), .start_y(start_y), .dxdx(dxdx), .dydx(dydx),
        .dxdy(dxdy), .dydy(dydy), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .gfx_addr(gfx_addr), .gfx_visible(gfx_visible),
        .gfx_valid(gfx_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected pixels as the design reports them (R5 R6 R7 R8 R9)
    always @(negedge clk) begin
        if (rst_n && gfx_valid) begin
            if (expq.size() == 0) begin
                check("R9 unexpected valid", 32'(gfx_valid), 32'd0);
            end else begin
                logic [24:0] e;
                e = expq.pop_front();
                check("R7 address", 32'(gfx_addr), 32'(e[23:0]));
                check("R8 visible", 32'(gfx_visible), 32'(e[24]));
            end
        end
    end

    task automatic cpu_write(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        ram_m[a] = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic do_frame();
        @(negedge clk);
        frame_start = 1'b1;
        lx = start_x; ly = start_y; px = start_x; py = start_y;
        first_line = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic do_line();
        @(negedge clk);
        line_start = 1'b1;
        if (first_line) begin
            first_line = 1'b0;       // R3
        end else begin
            lx = lx + dxdy;          // R4
            ly = ly + dydy;
        end
        px = lx; py = ly;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic pix_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [9:0]  idx;
            logic        vis;
            @(negedge clk);
            // R6: coordinate is acc[23:11]; truncated coordinate is acc[19:11]
            idx = {py[19:15], px[19:15]};
            vis = (px[23:20] == 4'd0) && (py[23:20] == 4'd0);
            expq.push_back({vis, ram_m[idx], py[14:11], px[14:11]});
            px = px + dxdx;          // R5
            py = py + dydx;
            pix_en = 1'b1;
        end
        @(negedge clk);
        pix_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame_run(input int lines, input int pixels);
        do_frame();
        for (int l = 0; l < lines; l++) begin
            do_line();
            pix_run(pixels);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [23:0] held;
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(gfx_valid), 32'd0);
        check("R1 visible", 32'(gfx_visible), 32'd0);
        check("R1 addr", 32'(gfx_addr), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 1024; i++)
            cpu_write(10'(i), 16'((i * 16'd40503) ^ 16'h5a3c));   // R10

        // identity mapping (R2 R3 R4 R5)
        start_x = 24'd0; start_y = 24'd0;
        dxdx = 24'd2048; dydx = 24'd0; dxdy = 24'd0; dydy = 24'd2048;
        frame_run(4, 40);

        // half-scale zoom with fractional start
        start_x = 24'h012345; start_y = 24'h0a0400;
        dxdx = 24'd1024; dydx = 24'd0; dxdy = 24'd0; dydy = 24'd1024;
        frame_run(3, 50);

        // rotation / shear, crossing tile boundaries
        start_x = 24'h07f000; start_y = 24'h03c000;
        dxdx = 24'd1774; dydx = 24'd1024; dxdy = -24'd1024; dydy = 24'd1774;
        frame_run(6, 60);

        // negative start: out of range then wrapping into the map (R8)
        start_x = -24'd20480; start_y = -24'd4096;
        dxdx = 24'd4096; dydx = 24'd0; dxdy = 24'd0; dydy = 24'd4096;
        frame_run(3, 30);

        // beyond 511 on X, still wrapped address (R8)
        start_x = 24'h0ff000; start_y = 24'h000800;
        dxdx = 24'd8192; dydx = 24'd0; dxdy = 24'd0; dydy = 24'd0;
        frame_run(2, 20);

        // R10: overwrite a tile then read it back through a pixel
        cpu_write(10'd0, 16'hbeef);
        start_x = 24'd0; start_y = 24'd0;
        dxdx = 24'd0; dydx = 24'd0; dxdy = 24'd0; dydy = 24'd0;
        frame_run(1, 2);

        // R9: outputs hold while no pixel strobe arrives
        held = gfx_addr;
        repeat (4) @(negedge clk);
        check("R9 hold addr", 32'(gfx_addr), 32'(held));
        check("R9 no valid", 32'(gfx_valid), 32'd0);
        check("R9 queue drained", 32'(expq.size()), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule